// File: doc/BRIEF.md
# Register-Mapped SPI Flash Command Engine

This block is a host-side SPI master placed behind an eight-byte register window. The host fills in an opcode byte, the low sixteen address bits and up to four data bytes. It then writes a control byte that names one of eleven fixed transaction shapes and carries address bits [19:16]. That write starts one flash transaction. The engine drives chip select, shifts the bytes out in SPI mode 0 and stores any returned bytes in the data registers, which the host reads back once busy drops.

The transaction shape is set by a 4-bit code and is not a free byte count. Because the address nibble sits in the control byte, only a 20-bit flash address space (1 MiB) can be reached. The SCK rate is the system clock divided by the even parameter `SCK_DIV`, which must be at least 2.

Top module: `spi_cmd_engine`

## Requirements
- R1: The window has eight byte registers: offset 0 opcode, 1 control, 2 address [15:8], 3 address [7:0], 4..7 data bytes 0..3. Each reads back its last written value, and all of them reset to 0x00.
- R2: A write to offset 1 whose bits [7:4] hold a code from 0x1 to 0xB starts a transaction. In the next cycle busy is high and chip select (active low) is asserted.
- R3: Codes 0x0 and 0xC to 0xF start nothing. Busy stays low, chip select stays high and nothing is shifted. The byte is still stored at offset 1.
- R4: Every transaction first sends the opcode. Codes 0x4 to 0xB then send a 3-byte address, most significant byte first: {4'h0, control[3:0]}, then offset 2, then offset 3. The shapes are: 1 opcode only; 2 one write byte; 3 two read bytes; 4 address only; 5 address plus one write byte; 6 address plus four write bytes; 7 address, dummy, four read bytes; 8/9/A/B address plus 1/2/3/4 read bytes.
- R5: Write bytes are sent from data byte 0 (offset 4) upward.
- R6: Read bytes are stored from data byte 0 upward, in the order they arrive. Data registers beyond the read count keep their values.
- R7: In code 0x7 the engine sends a 0x00 dummy byte after the address and discards whatever arrives on MISO during it.
- R8: SPI mode 0. SCK is low whenever chip select is high. Bits go MSB first, and MOSI is stable while SCK is high. MISO is sampled on the SCK rising edge.
- R9: While busy, host writes to any offset are ignored, including writes to the control register.
- R10: A transaction of N bytes keeps busy high for exactly N*(8*SCK_DIV+1)+SCK_DIV clock cycles. Chip select is released one SCK period after the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register window write strobe |
| reg_addr_i | input | 3 | Register window offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the addressed register (combinational) |
| busy_o | output | 1 | Transaction in progress |
| spi_sck_o | output | 1 | SPI clock, idles low |
| spi_cs_no | output | 1 | SPI chip select, active low |
| spi_mosi_o | output | 1 | SPI serial data out |
| spi_miso_i | input | 1 | SPI serial data in |

## Verification
Each of the eleven codes is run with its own opcode, address and data bytes against a flash slave model. The slave records MOSI and answers with a byte pattern that depends on byte position, which makes a wrong byte order, a missing or extra address byte, or a dummy byte that was not discarded show up as distinct mismatches. Code 0x8 runs with the data registers preloaded, so a read that overwrites bytes beyond its count is caught. The five unused codes and writes made during a transaction check that nothing starts and nothing changes. The exact busy duration for every shape shows whether byte pacing and the chip-select tail are right.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned N_DATA = 4;
  localparam int unsigned DIDX_W = $clog2(N_DATA);

  typedef struct packed {
    logic       valid;
    logic       has_addr;
    logic       dummy;
    logic [2:0] n_wr;
    logic [2:0] n_rd;
  } shape_t;

  function automatic shape_t decode_shape(input logic [3:0] code);
    shape_t s;
    s = '0;
    s.valid = 1'b1;
    case (code)
      4'h1: ;
      4'h2: s.n_wr = 3'd1;
      4'h3: s.n_rd = 3'd2;
      4'h4: s.has_addr = 1'b1;
      4'h5: begin s.has_addr = 1'b1; s.n_wr = 3'd1; end
      4'h6: begin s.has_addr = 1'b1; s.n_wr = 3'd4; end
      4'h7: begin s.has_addr = 1'b1; s.dummy = 1'b1; s.n_rd = 3'd4; end
      4'h8, 4'h9, 4'hA, 4'hB: begin
        s.has_addr = 1'b1;
        s.n_rd     = 3'(code - 4'h7);
      end
      default: s.valid = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         host_we_i,
  input  logic [2:0]                   host_addr_i,
  input  logic [7:0]                   host_wdata_i,
  input  logic                         busy_i,
  input  logic                         cap_we_i,
  input  logic [DIDX_W-1:0]            cap_idx_i,
  input  logic [7:0]                   cap_data_i,
  output logic [7:0]                   rdata_o,
  output logic [7:0]                   opcode_o,
  output logic [7:0]                   ctrl_o,
  output logic [7:0]                   addr_hi_o,
  output logic [7:0]                   addr_lo_o,
  output logic [N_DATA-1:0][7:0]       data_o
);
  logic acc;
  assign acc = host_we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opcode_o  <= '0;
      ctrl_o    <= '0;
      addr_hi_o <= '0;
      addr_lo_o <= '0;
    end else if (acc) begin
      case (host_addr_i)
        3'd0: opcode_o  <= host_wdata_i;
        3'd1: ctrl_o    <= host_wdata_i;
        3'd2: addr_hi_o <= host_wdata_i;
        3'd3: addr_lo_o <= host_wdata_i;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_DATA; g++) begin : g_data
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        data_o[g] <= '0;
      else if (cap_we_i && cap_idx_i == DIDX_W'(g))
        data_o[g] <= cap_data_i;
      else if (acc && host_addr_i[2] && host_addr_i[1:0] == 2'(g))
        data_o[g] <= host_wdata_i;
    end
  end

  always_comb begin
    case (host_addr_i)
      3'd0:    rdata_o = opcode_o;
      3'd1:    rdata_o = ctrl_o;
      3'd2:    rdata_o = addr_hi_o;
      3'd3:    rdata_o = addr_lo_o;
      default: rdata_o = data_o[host_addr_i[1:0]];
    endcase
  end

  // R9: a write during busy leaves the window untouched
  p_busy_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && host_we_i && !cap_we_i) |=>
      ($stable(opcode_o) && $stable(ctrl_o) && $stable(addr_hi_o)
       && $stable(addr_lo_o) && $stable(data_o)));
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
  parameter int unsigned SCK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int unsigned HALF = (SCK_DIV < 2) ? 1 : SCK_DIV / 2;
  localparam int unsigned DW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic          active, phase, tick;
  logic [DW-1:0] div_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    tx_q;

  assign tick   = (div_cnt == DW'(HALF - 1));
  assign sck_o  = active && phase;
  assign mosi_o = active && tx_q[7];
  assign done_o = active && tick && phase && (bit_cnt == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active  <= 1'b0;
      phase   <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_q    <= '0;
      rx_o    <= '0;
    end else if (start_i) begin
      active  <= 1'b1;
      phase   <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_q    <= tx_i;
    end else if (active) begin
      if (tick) begin
        div_cnt <= '0;
        if (!phase) begin
          phase <= 1'b1;
          rx_o  <= {rx_o[6:0], miso_i};  // rising edge sample
        end else begin
          phase <= 1'b0;
          if (bit_cnt == 3'd7) begin
            active <= 1'b0;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
            tx_q    <= {tx_q[6:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + DW'(1);
      end
    end
  end

  // R8: MOSI holds while SCK is high
  p_mosi_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int unsigned SCK_DIV = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   trig_i,
  input  shape_t                 shape_i,
  input  logic [3:0]             nib_i,
  input  logic [7:0]             opcode_i,
  input  logic [7:0]             addr_hi_i,
  input  logic [7:0]             addr_lo_i,
  input  logic [N_DATA-1:0][7:0] data_i,
  input  logic                   byte_done_i,
  input  logic [7:0]             rx_byte_i,
  output logic                   busy_o,
  output logic                   cs_no,
  output logic                   byte_start_o,
  output logic [7:0]             tx_byte_o,
  output logic                   cap_we_o,
  output logic [DIDX_W-1:0]      cap_idx_o,
  output logic [7:0]             cap_data_o
);
  localparam int unsigned TW = $clog2(SCK_DIV + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_XFER, S_TAIL} state_e;
  state_e        state;
  logic [3:0]    idx, hdr_len, total, rel, rd_rel;
  logic [TW-1:0] tail_cnt;
  logic          rd_slot, last_byte;

  // shape registers are held stable by the busy write lock
  assign hdr_len   = 4'd1 + (shape_i.has_addr ? 4'd3 : 4'd0) + 4'(shape_i.dummy);
  assign total     = hdr_len + 4'(shape_i.n_wr) + 4'(shape_i.n_rd);
  assign rel       = idx - hdr_len;
  assign rd_rel    = rel - 4'(shape_i.n_wr);
  assign rd_slot   = (idx >= hdr_len) && (rel >= 4'(shape_i.n_wr));
  assign last_byte = (idx == total - 4'd1);

  always_comb begin
    tx_byte_o = 8'h00;
    if (idx < hdr_len) begin
      case (idx)
        4'd0: tx_byte_o = opcode_i;
        4'd1: tx_byte_o = {4'h0, nib_i};
        4'd2: tx_byte_o = addr_hi_i;
        4'd3: tx_byte_o = addr_lo_i;
        default: tx_byte_o = 8'h00;  // dummy
      endcase
    end else if (rel < 4'(shape_i.n_wr)) begin
      tx_byte_o = data_i[rel[DIDX_W-1:0]];
    end
  end

  assign busy_o       = (state != S_IDLE);
  assign cs_no        = (state == S_IDLE);
  assign byte_start_o = (state == S_LOAD);
  assign cap_we_o     = (state == S_XFER) && byte_done_i && rd_slot;
  assign cap_idx_o    = rd_rel[DIDX_W-1:0];
  assign cap_data_o   = rx_byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= S_IDLE;
      idx      <= '0;
      tail_cnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (trig_i) begin
          state <= S_LOAD;
          idx   <= '0;
        end
        S_LOAD: state <= S_XFER;
        S_XFER: if (byte_done_i) begin
          if (last_byte) begin
            state    <= S_TAIL;
            tail_cnt <= '0;
          end else begin
            idx   <= idx + 4'd1;
            state <= S_LOAD;
          end
        end
        S_TAIL: begin
          if (tail_cnt == TW'(SCK_DIV - 1)) state <= S_IDLE;
          else tail_cnt <= tail_cnt + TW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: the shifter finishes a byte only while one is in flight
  p_done_in_xfer_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_i |-> (state == S_XFER));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int unsigned SCK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [2:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       busy_o,
  output logic       spi_sck_o,
  output logic       spi_cs_no,
  output logic       spi_mosi_o,
  input  logic       spi_miso_i
);
  logic [7:0]             opcode, ctrl, addr_hi, addr_lo, tx_byte, rx_byte, cap_data;
  logic [N_DATA-1:0][7:0] data;
  logic                   cap_we, byte_start, byte_done, trig;
  logic [DIDX_W-1:0]      cap_idx;
  shape_t                 shape, new_shape;

  assign new_shape = decode_shape(reg_wdata_i[7:4]);
  assign shape     = decode_shape(ctrl[7:4]);
  assign trig      = reg_we_i && !busy_o && (reg_addr_i == 3'd1) && new_shape.valid;

  spi_cmd_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_we_i   (reg_we_i),
    .host_addr_i (reg_addr_i),
    .host_wdata_i(reg_wdata_i),
    .busy_i      (busy_o),
    .cap_we_i    (cap_we),
    .cap_idx_i   (cap_idx),
    .cap_data_i  (cap_data),
    .rdata_o     (reg_rdata_o),
    .opcode_o    (opcode),
    .ctrl_o      (ctrl),
    .addr_hi_o   (addr_hi),
    .addr_lo_o   (addr_lo),
    .data_o      (data)
  );

  spi_cmd_seq #(.SCK_DIV(SCK_DIV)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig),
    .shape_i     (shape),
    .nib_i       (ctrl[3:0]),
    .opcode_i    (opcode),
    .addr_hi_i   (addr_hi),
    .addr_lo_i   (addr_lo),
    .data_i      (data),
    .byte_done_i (byte_done),
    .rx_byte_i   (rx_byte),
    .busy_o      (busy_o),
    .cs_no       (spi_cs_no),
    .byte_start_o(byte_start),
    .tx_byte_o   (tx_byte),
    .cap_we_o    (cap_we),
    .cap_idx_o   (cap_idx),
    .cap_data_o  (cap_data)
  );

  spi_cmd_shift #(.SCK_DIV(SCK_DIV)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(byte_start),
    .tx_i   (tx_byte),
    .miso_i (spi_miso_i),
    .sck_o  (spi_sck_o),
    .mosi_o (spi_mosi_o),
    .done_o (byte_done),
    .rx_o   (rx_byte)
  );

  p_idle_sck_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !busy_o && reg_addr_i == 3'd1 && reg_wdata_i[7:4] != 4'h0
     && reg_wdata_i[7:4] <= 4'hB) |=> (busy_o && !spi_cs_no));

  p_no_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !busy_o && reg_addr_i == 3'd1
     && (reg_wdata_i[7:4] == 4'h0 || reg_wdata_i[7:4] > 4'hB)) |=> (!busy_o && spi_cs_no));
endmodule

// File: tb/test_spi_cmd_engine.sv
module test_spi_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy, sck, cs_n, mosi;
  logic       miso = 1'b0;

  int n_cmp = 0, n_bad = 0;
  int bitcnt = 0;
  logic [7:0] shreg = '0;
  logic [7:0] mosi_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_cmd_engine #(.SCK_DIV(DIV)) i_spi_cmd_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .busy_o(busy),
    .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  function automatic logic [7:0] resp(input int k);
    return 8'(8'h5A ^ (k * 37));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // flash slave model
  always @(negedge cs_n) begin
    bitcnt = 0;
    miso   = resp(0)[7];
  end
  always @(posedge sck) begin
    shreg  = {shreg[6:0], mosi};
    bitcnt = bitcnt + 1;
    if (bitcnt % 8 == 0) mosi_q.push_back(shreg);
    miso = resp(bitcnt / 8)[7 - (bitcnt % 8)];
  end

  // per-clock interface compare (R8, R2)
  always @(negedge clk) if (rst_n) begin
    chk(!(cs_n && sck), "R8 sck idle low", int'(sck), 0);
    chk(cs_n == !busy, "R2 cs tracks busy", int'(cs_n), int'(!busy));
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic do_txn(input logic [3:0] code, input logic [3:0] nib,
                        input logic [7:0] op, input logic [7:0] hi, input logic [7:0] lo);
    bit has_a, dum;
    int nw, nr, n, cyc, first_rd;
    logic [7:0] pre[4];
    logic [7:0] exp_q[$];
    logic [7:0] v;
    has_a = (code >= 4);
    dum   = (code == 7);
    nw    = (code == 2 || code == 5) ? 1 : (code == 6) ? 4 : 0;
    nr    = (code == 3) ? 2 : (code == 7) ? 4 : (code >= 8) ? int'(code) - 7 : 0;
    n     = 1 + (has_a ? 3 : 0) + int'(dum) + nw + nr;
    wr(0, op); wr(2, hi); wr(3, lo);
    for (int j = 0; j < 4; j++) begin
      pre[j] = 8'(8'h11 * (j + 1) + code);
      wr(3'(4 + j), pre[j]);
    end
    mosi_q.delete();
    wr(1, {code, nib});
    chk(busy && !cs_n, $sformatf("R2 start code %0h", code), int'(busy), 1);
    cyc = 0;
    while (busy && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == n * (8 * DIV + 1) + DIV, $sformatf("R10 busy cycles code %0h", code),
        cyc, n * (8 * DIV + 1) + DIV);
    exp_q.push_back(op);
    if (has_a) begin
      exp_q.push_back({4'h0, nib}); exp_q.push_back(hi); exp_q.push_back(lo);
    end
    if (dum) exp_q.push_back(8'h00);
    for (int j = 0; j < nw; j++) exp_q.push_back(pre[j]);
    for (int j = 0; j < nr; j++) exp_q.push_back(8'h00);
    chk(mosi_q.size() == exp_q.size(), $sformatf("R4 byte count code %0h", code),
        mosi_q.size(), exp_q.size());
    for (int k = 0; k < exp_q.size() && k < mosi_q.size(); k++)
      chk(mosi_q[k] == exp_q[k],
          $sformatf("%s mosi byte %0d code %0h",
                    (dum && k == 4) ? "R7" : (k > 3 && nw > 0) ? "R5" : "R4", k, code),
          mosi_q[k], exp_q[k]);
    first_rd = n - nr;
    for (int j = 0; j < 4; j++) begin
      logic [7:0] e;
      e = (j < nr) ? resp(first_rd + j) : pre[j];
      rd(3'(4 + j), v);
      chk(v == e, $sformatf("%s data reg %0d code %0h", dum ? "R7" : "R6", j, code), v, e);
    end
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(v == 8'h00, "R1 reset value", v, 0);
    end
    chk(!busy && cs_n && !sck, "R1 reset idle", int'({busy, cs_n, sck}), 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 readback (control uses an unused code so nothing starts)
    for (int a = 0; a < 8; a++) begin
      wr(3'(a), 8'(8'hC0 + a * 3));
      rd(3'(a), v);
      chk(v == 8'(8'hC0 + a * 3), "R1 readback", v, 8'hC0 + a * 3);
    end
    chk(!busy, "R3 code C idle", int'(busy), 0);

    do_txn(4'h1, 4'h0, 8'h06, 8'h00, 8'h00);
    do_txn(4'h2, 4'h0, 8'h01, 8'h00, 8'h00);
    do_txn(4'h3, 4'h0, 8'h9F, 8'h00, 8'h00);
    do_txn(4'h4, 4'hA, 8'h20, 8'h34, 8'h56);
    do_txn(4'h5, 4'h3, 8'h02, 8'h81, 8'h7E);
    do_txn(4'h6, 4'hF, 8'h02, 8'hFF, 8'h00);
    do_txn(4'h7, 4'h5, 8'h0B, 8'h12, 8'h9C);
    do_txn(4'h8, 4'h1, 8'h03, 8'hA5, 8'h5A);
    do_txn(4'h9, 4'h9, 8'h03, 8'h00, 8'hFF);
    do_txn(4'hA, 4'h6, 8'h03, 8'h40, 8'h01);
    do_txn(4'hB, 4'hC, 8'h03, 8'hDE, 8'hAD);

    // R3 unused codes
    foreach (v[i]) ;
    for (int c = 0; c < 16; c++) begin
      if (c >= 1 && c <= 11) continue;
      mosi_q.delete();
      wr(1, 8'(c * 16 + 7));
      chk(!busy && cs_n, $sformatf("R3 code %0h no start", c), int'(busy), 0);
      repeat (4) @(negedge clk);
      chk(mosi_q.size() == 0, "R3 nothing shifted", mosi_q.size(), 0);
      rd(1, v);
      chk(v == 8'(c * 16 + 7), "R3 control stored", v, c * 16 + 7);
    end

    // R9 writes while busy
    wr(0, 8'h66); wr(4, 8'h77);
    wr(1, 8'h10);
    wr(0, 8'h99); wr(4, 8'h88); wr(1, 8'hB0);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy, "R9 no retrigger", int'(busy), 0);
    rd(0, v); chk(v == 8'h66, "R9 opcode kept", v, 8'h66);
    rd(4, v); chk(v == 8'h77, "R9 data kept", v, 8'h77);
    rd(1, v); chk(v == 8'h10, "R9 control kept", v, 8'h10);

    summary();
  end
endmodule